// File: doc/BRIEF.md
# Nibble-Bus Divider Ratio Register File

This block stores the three divide ratios of a frequency synthesizer. A host writes them four bits at a time over a narrow bus that has a 3-bit address and a single strobe line. Eight nibble latches hold the words. Each latch takes the bus value while the strobe is high and keeps it once the strobe falls. The latches are combined into three words of unequal width: a 7-bit swallow count, a 10-bit main count and a 12-bit reference count. The divider logic reads these words directly.

Capture is synchronous to a system clock. On every clock edge where the strobe is high, the addressed latch loads the bus, so the latch follows the bus for as long as the strobe stays high. When the strobe drops, the last value loaded stays put. A status output flags a combination of ratios that the dividers cannot use.

Top module: `nbl_regfile`

## Requirements
- R1: While rst_ni is low, every latch clears, so swallow_o, main_o and ref_o all read 0.
- R2: On a clock edge with strobe_i high, the latch selected by addr_i loads data_i. Bit 3 of data_i is the most significant bit of the nibble. No other latch changes.
- R3: On a clock edge with strobe_i low, no latch changes, whatever addr_i and data_i carry.
- R4: Across several clock edges with strobe_i high, the addressed latch takes the newest bus value each time. After strobe_i falls, the last value taken is held.
- R5: swallow_o is {latch 1 bits 2:0, latch 0}. Bit 3 written to latch 1 has no effect.
- R6: main_o is {latch 4 bits 1:0, latch 3, latch 2}. Bits 3:2 written to latch 4 have no effect.
- R7: ref_o is {latch 7, latch 6, latch 5}.
- R8: illegal_o is high exactly when main_o < 3, or ref_o < 3, or swallow_o > main_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 4 | Nibble bus; bit 3 is the MSB |
| addr_i | input | 3 | Latch select, 0 to 7 |
| strobe_i | input | 1 | Write strobe, idles low |
| swallow_o | output | 7 | Swallow count |
| main_o | output | 10 | Main count |
| ref_o | output | 12 | Reference count |
| illegal_o | output | 1 | Ratio set unusable |

## Verification
The bench targets the following corner cases:
- **Latches with a partly used nibble (1 and 4).** These receive values whose unused upper bits are set. A design that packed the whole nibble would shift the next field or overflow the word.
- **Changing bus under a long strobe.** The bus changes while the strobe is held high, and then again after the strobe falls. A design that kept the first value, or that kept loading after the fall, would hold the wrong value.
- **Illegal-ratio thresholds.** The status output is exercised right at its limits: main equal to swallow, main of 2 against 3, and reference of 2 against 3. An off-by-one compare would mark these the wrong way.
- **Full-scale words and reset.** Full-scale main and reference values are loaded, and a reset is applied mid-run. This exposes any truncated field and any latch left out of the reset.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic [1:0] {FLD_SWALLOW, FLD_MAIN, FLD_REF} fld_e;

  function automatic int nib_cnt(input int w, input int nibw);
    return (w + nibw - 1) / nibw;
  endfunction

  function automatic fld_e lat_field(input int i, input int aw, input int nw, input int nibw);
    if (i < nib_cnt(aw, nibw)) return FLD_SWALLOW;
    if (i < nib_cnt(aw, nibw) + nib_cnt(nw, nibw)) return FLD_MAIN;
    return FLD_REF;
  endfunction

  // nibble index of latch i inside its own field
  function automatic int lat_rank(input int i, input int aw, input int nw, input int nibw);
    case (lat_field(i, aw, nw, nibw))
      FLD_SWALLOW: return i;
      FLD_MAIN:    return i - nib_cnt(aw, nibw);
      default:     return i - nib_cnt(aw, nibw) - nib_cnt(nw, nibw);
    endcase
  endfunction

  function automatic int lat_width(input int i, input int aw, input int nw, input int rw,
                                   input int nibw);
    int fw;
    int rem;
    case (lat_field(i, aw, nw, nibw))
      FLD_SWALLOW: fw = aw;
      FLD_MAIN:    fw = nw;
      default:     fw = rw;
    endcase
    rem = fw - lat_rank(i, aw, nw, nibw) * nibw;
    return (rem < nibw) ? rem : nibw;
  endfunction

  function automatic int lat_base(input int i, input int aw, input int nw, input int nibw);
    int off;
    case (lat_field(i, aw, nw, nibw))
      FLD_SWALLOW: off = 0;
      FLD_MAIN:    off = aw;
      default:     off = aw + nw;
    endcase
    return off + lat_rank(i, aw, nw, nibw) * nibw;
  endfunction

endpackage

// File: rtl/nbl_addr_dec.sv
module nbl_addr_dec #(
  parameter int NUM_LAT = 8,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               strobe_i,
  output logic [NUM_LAT-1:0] we_o
);

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_we
    assign we_o[i] = strobe_i && (addr_i == ADDR_W'(i));
  end

endmodule

// File: rtl/nbl_latch_bank.sv
module nbl_latch_bank #(
  parameter int NIB_W   = 4,
  parameter int A_W     = 7,
  parameter int N_W     = 10,
  parameter int R_W     = 12,
  parameter int NUM_LAT = 8,
  parameter int TOT_W   = 29
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NIB_W-1:0]   data_i,
  input  logic [NUM_LAT-1:0] we_i,
  output logic [TOT_W-1:0]   store_o
);

  // only the bits a field actually uses are stored
  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    localparam int W = nbl_pkg::lat_width(i, A_W, N_W, R_W, NIB_W);
    localparam int B = nbl_pkg::lat_base(i, A_W, N_W, NIB_W);
    logic [W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= '0;
      else if (we_i[i])  q <= data_i[W-1:0];
    end

    assign store_o[B +: W] = q;
  end

endmodule

// File: rtl/nbl_field_pack.sv
module nbl_field_pack #(
  parameter int A_W     = 7,
  parameter int N_W     = 10,
  parameter int R_W     = 12,
  parameter int MIN_DIV = 3,
  parameter int TOT_W   = 29
) (
  input  logic [TOT_W-1:0] store_i,
  output logic [A_W-1:0]   swallow_o,
  output logic [N_W-1:0]   main_o,
  output logic [R_W-1:0]   ref_o,
  output logic             illegal_o
);

  assign swallow_o = store_i[0 +: A_W];
  assign main_o    = store_i[A_W +: N_W];
  assign ref_o     = store_i[A_W + N_W +: R_W];

  logic main_low, ref_low, swallow_big;
  assign main_low    = main_o < N_W'(MIN_DIV);
  assign ref_low     = ref_o < R_W'(MIN_DIV);
  assign swallow_big = {{(N_W - A_W){1'b0}}, swallow_o} > main_o;
  assign illegal_o   = main_low || ref_low || swallow_big;

endmodule

// File: rtl/nbl_regfile.sv
module nbl_regfile #(
  parameter int NIB_W   = 4,
  parameter int A_W     = 7,
  parameter int N_W     = 10,
  parameter int R_W     = 12,
  parameter int MIN_DIV = 3,
  localparam int NUM_LAT = nbl_pkg::nib_cnt(A_W, NIB_W) + nbl_pkg::nib_cnt(N_W, NIB_W)
                           + nbl_pkg::nib_cnt(R_W, NIB_W),
  localparam int ADDR_W  = $clog2(NUM_LAT),
  localparam int TOT_W   = A_W + N_W + R_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  output logic [A_W-1:0]    swallow_o,
  output logic [N_W-1:0]    main_o,
  output logic [R_W-1:0]    ref_o,
  output logic              illegal_o
);

  logic [NUM_LAT-1:0] we;
  logic [TOT_W-1:0]   store;

  nbl_addr_dec #(.NUM_LAT(NUM_LAT), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .strobe_i (strobe_i),
    .we_o     (we)
  );

  nbl_latch_bank #(
    .NIB_W(NIB_W), .A_W(A_W), .N_W(N_W), .R_W(R_W), .NUM_LAT(NUM_LAT), .TOT_W(TOT_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .we_i    (we),
    .store_o (store)
  );

  nbl_field_pack #(
    .A_W(A_W), .N_W(N_W), .R_W(R_W), .MIN_DIV(MIN_DIV), .TOT_W(TOT_W)
  ) u_pack (
    .store_i   (store),
    .swallow_o (swallow_o),
    .main_o    (main_o),
    .ref_o     (ref_o),
    .illegal_o (illegal_o)
  );

endmodule

// File: rtl/nbl_regfile_chk.sv
module nbl_regfile_chk #(
  parameter int NIB_W   = 4,
  parameter int A_W     = 7,
  parameter int N_W     = 10,
  parameter int R_W     = 12,
  parameter int MIN_DIV = 3,
  parameter int ADDR_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_i,
  input logic [A_W-1:0]    swallow_o,
  input logic [N_W-1:0]    main_o,
  input logic [R_W-1:0]    ref_o,
  input logic              illegal_o
);

  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(nbl_pkg::nib_cnt(A_W, NIB_W));
  localparam logic [ADDR_W-1:0] N_END = ADDR_W'(nbl_pkg::nib_cnt(A_W, NIB_W)
                                                + nbl_pkg::nib_cnt(N_W, NIB_W));

  logic strobe_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> (swallow_o == '0 && main_o == '0 && ref_o == '0));

  // R2: a write touches only its own field
  a_r2_swallow_write_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i < A_END) |=> ($stable(main_o) && $stable(ref_o)));
  a_r2_main_write_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i >= A_END && addr_i < N_END) |=> ($stable(swallow_o) && $stable(ref_o)));
  a_r2_ref_write_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i >= N_END) |=> ($stable(swallow_o) && $stable(main_o)));

  // R3
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(swallow_o) && $stable(main_o) && $stable(ref_o)));

  // R4: after the strobe falls nothing moves
  a_r4_freeze_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && !strobe_i) |=> ($stable(swallow_o) && $stable(main_o) && $stable(ref_o)));

  // R8
  a_r8_swallow_over_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(N_W - A_W){1'b0}}, swallow_o} > main_o) |-> illegal_o);
  a_r8_ref_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o < R_W'(MIN_DIV)) |-> illegal_o);
  a_r8_legal_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_o >= N_W'(MIN_DIV) && ref_o >= R_W'(MIN_DIV)
     && {{(N_W - A_W){1'b0}}, swallow_o} <= main_o) |-> !illegal_o);

endmodule

bind nbl_regfile nbl_regfile_chk #(
  .NIB_W(NIB_W), .A_W(A_W), .N_W(N_W), .R_W(R_W), .MIN_DIV(MIN_DIV), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .strobe_i  (strobe_i),
  .swallow_o (swallow_o),
  .main_o    (main_o),
  .ref_o     (ref_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_nbl_regfile.sv
module tb_nbl_regfile;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  data_i = '0;
  logic [2:0]  addr_i = '0;
  logic        strobe_i = 1'b0;
  logic [6:0]  swallow_o;
  logic [9:0]  main_o;
  logic [11:0] ref_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  nbl_regfile dut (
    .clk_i, .rst_ni, .data_i, .addr_i, .strobe_i,
    .swallow_o, .main_o, .ref_o, .illegal_o
  );

  typedef struct packed {
    logic [2:0]  addr;
    logic [3:0]  data;
    logic [6:0]  a;
    logic [9:0]  n;
    logic [11:0] r;
    logic        ill;
  } vec_t;

  // cumulative: each row is one strobed write and the state expected after it
  localparam vec_t VECS [21] = '{
    '{3'd0, 4'h5, 7'd5,   10'd0,   12'd0,    1'b1},
    '{3'd1, 4'hF, 7'd117, 10'd0,   12'd0,    1'b1},  // latch 1 bit 3 dropped
    '{3'd2, 4'h9, 7'd117, 10'd9,   12'd0,    1'b1},
    '{3'd3, 4'hC, 7'd117, 10'd201, 12'd0,    1'b1},
    '{3'd4, 4'hE, 7'd117, 10'd713, 12'd0,    1'b1},  // latch 4 bits 3:2 dropped
    '{3'd5, 4'h2, 7'd117, 10'd713, 12'd2,    1'b1},
    '{3'd6, 4'h0, 7'd117, 10'd713, 12'd2,    1'b1},
    '{3'd7, 4'hA, 7'd117, 10'd713, 12'd2562, 1'b0},
    '{3'd1, 4'h0, 7'd5,   10'd713, 12'd2562, 1'b0},
    '{3'd4, 4'h0, 7'd5,   10'd201, 12'd2562, 1'b0},
    '{3'd3, 4'h0, 7'd5,   10'd9,   12'd2562, 1'b0},
    '{3'd0, 4'hF, 7'd15,  10'd9,   12'd2562, 1'b1},  // swallow > main
    '{3'd2, 4'hF, 7'd15,  10'd15,  12'd2562, 1'b0},  // swallow == main
    '{3'd2, 4'h2, 7'd15,  10'd2,   12'd2562, 1'b1},  // main = 2
    '{3'd2, 4'h3, 7'd15,  10'd3,   12'd2562, 1'b1},
    '{3'd0, 4'h3, 7'd3,   10'd3,   12'd2562, 1'b0},  // main = 3 legal
    '{3'd7, 4'h0, 7'd3,   10'd3,   12'd2,    1'b1},  // ref = 2
    '{3'd5, 4'h3, 7'd3,   10'd3,   12'd3,    1'b0},  // ref = 3 legal
    '{3'd6, 4'hF, 7'd3,   10'd3,   12'd243,  1'b0},
    '{3'd1, 4'h8, 7'd3,   10'd3,   12'd243,  1'b0},
    '{3'd4, 4'hF, 7'd3,   10'd771, 12'd243,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [6:0] a, input logic [9:0] n,
                         input logic [11:0] r, input logic ill);
    chk({req, " swallow"}, 32'(swallow_o), 32'(a));
    chk({req, " main"},    32'(main_o),    32'(n));
    chk({req, " ref"},     32'(ref_o),     32'(r));
    chk({req, " illegal"}, 32'(illegal_o), 32'(ill));
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog got 0 exp 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk_all("R1 reset", 7'd0, 10'd0, 12'd0, 1'b1);
    rst_ni = 1'b1;

    // R2 R5 R6 R7 R8 vector walk
    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].data);
      chk_all("R2/R5/R6/R7/R8 vec", VECS[i].a, VECS[i].n, VECS[i].r, VECS[i].ill);
    end

    // R3: bus activity with strobe low is ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      addr_i = 3'(k); data_i = 4'(k + 5);
    end
    @(negedge clk_i);
    chk_all("R3 idle bus", 7'd3, 10'd771, 12'd243, 1'b0);

    // R4: long strobe, bus changing; last value wins and is held
    @(negedge clk_i);
    addr_i = 3'd5; data_i = 4'h1; strobe_i = 1'b1;
    @(negedge clk_i);
    chk("R4 transparent", 32'(ref_o), 32'd241);
    data_i = 4'h4;
    @(negedge clk_i);
    chk("R4 transparent", 32'(ref_o), 32'd244);
    data_i = 4'h6;
    @(negedge clk_i);
    strobe_i = 1'b0;
    data_i = 4'h9;
    repeat (3) @(negedge clk_i);
    chk("R4 held", 32'(ref_o), 32'd246);

    // R6 R7: full-scale words
    wr(3'd2, 4'hF); wr(3'd3, 4'hF); wr(3'd4, 4'hF);
    wr(3'd5, 4'hF); wr(3'd6, 4'hF); wr(3'd7, 4'hF);
    chk_all("R6/R7 full scale", 7'd3, 10'd1023, 12'd4095, 1'b0);

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_all("R1 mid reset", 7'd0, 10'd0, 12'd0, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    summary();
  end

endmodule